// File: doc/BRIEF.md
# Sliding-Window Partial SVM Accumulator

This block scores every detection window of a frame with a linear classifier without ever holding a whole window of features. Normalized block feature vectors arrive in raster order. Each one carries its block column and row. For each block the block works out the rectangle of windows that contain it: the first window is the block's position minus the window extent plus one, clamped at zero; the last window is the block's position, clamped at the last window position. It then visits those windows row by row. For each visited window it takes the weight slice that belongs to the block's offset inside the window and forms the dot product with the block vector. It adds that product to the window's partial score in an on-chip score memory and writes the result back.

A window's partial score starts from zero when its top-left block arrives. When its bottom-right block arrives, the bias is added and the block emits a one-cycle result: the window index, the final score and the class. Incoming blocks wait in a small input FIFO, because a block that falls in several windows takes several cycles; a ready signal pushes back on the source when the FIFO is full. Weights are loaded through a simple write port before a frame. The bias is a static input.

Frame size, window size and block size are given in pixels as parameters, and the block-grid sizes are derived from them. With the defaults, a 96x64 frame, 32x32 windows and 16x16 blocks give a 6x4 block grid and a 5x3 grid of 15 windows.

Top module: `swin_svm_acc`

## Requirements
- R1: After reset, `win_valid_o` is 0 and `blk_ready_o` is 1.
- R2: Windows are numbered linearly as `wr*WPR + wc`, where `WPR = (FRAME_W-WIN_W)/BLK_W + 1`. Each window is reported exactly once per frame. When blocks arrive in raster order, the reports come out in ascending index order.
- R3: The reported score of window (wc, wr) is `bias_i` plus the sum, over every block (wc+pc, wr+pr) inside the window and every component k, of `W[(pr*WIN_W/BLK_W + pc)*VEC_LEN + k] * x[k]`. Features and weights are two's-complement.
- R4: `win_class_o` is 1 when the reported score is greater than or equal to 0, and 0 when it is negative. A score of exactly 0 is positive.
- R5: A window's partial score is cleared when its top-left block is processed, so consecutive frames give independent scores.
- R6: `blk_ready_o` is 0 while the input FIFO is full. A block is accepted only when `blk_valid_i` and `blk_ready_o` are both 1, and no accepted block is lost.
- R7: `win_valid_o` is a one-cycle pulse; it is never high in two consecutive cycles.
- R8: A cycle with `wgt_we_i` high writes `wgt_data_i` to weight address `wgt_addr_i`. A reloaded weight set is used for all blocks accepted afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Classifier clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blk_valid_i | input | 1 | Block vector offered |
| blk_ready_o | output | 1 | Input FIFO can take a block |
| blk_col_i | input | COL_W | Block column in the frame |
| blk_row_i | input | ROW_W | Block row in the frame |
| blk_vec_i | input | VEC_LEN*FEAT_W | Block vector, component k at bits [k*FEAT_W +: FEAT_W], signed |
| wgt_we_i | input | 1 | Weight write enable |
| wgt_addr_i | input | WA_W | Weight address |
| wgt_data_i | input | WGT_W | Weight value, signed |
| bias_i | input | SCORE_W | Classifier bias, signed |
| win_valid_o | output | 1 | Window result pulse |
| win_idx_o | output | IDX_W | Linear window index |
| win_class_o | output | 1 | 1 = positive, 0 = negative |
| win_score_o | output | SCORE_W | Final window score, signed |

## Verification
A wrong first-window or replication computation makes a block land in the wrong set of windows. This shows at the ports as a wrong score, or as a missing or out-of-order index, no later than the report of the first window whose bottom-right block follows the faulty one. A partial score that is not cleared carries one frame into the next, so the first window reported in the second frame already shows a score offset. The bench sweeps every window of the grid over four frames: two weight sets, buffered and back-to-back feeding, and a zero-feature frame with the bias on either side of zero. It checks every index, score and class against sums computed in the bench.

// File: rtl/swsvm_pkg.sv
package swsvm_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} state_t;
endpackage

// File: rtl/swsvm_fifo.sv
module swsvm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] cnt_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign data_o  = mem[rd_ptr];
  assign cnt_o   = cnt;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_i) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/swsvm_idx_gen.sv
// Window rectangle containing a block, plus linear index of its first window.
module swsvm_idx_gen #(
  parameter int FBW   = 6,
  parameter int FBH   = 4,
  parameter int WBW   = 2,
  parameter int WBH   = 2,
  parameter int COL_W = 3,
  parameter int ROW_W = 3,
  parameter int IDX_W = 4,
  localparam int WPR  = FBW - WBW + 1,
  localparam int WPC  = FBH - WBH + 1
) (
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [COL_W-1:0] fc_o,
  output logic [COL_W-1:0] lc_o,
  output logic [ROW_W-1:0] fr_o,
  output logic [ROW_W-1:0] lr_o,
  output logic [IDX_W-1:0] first_o
);
  always_comb begin
    int c, r, fc, lc, fr, lr;
    c  = int'(col_i);
    r  = int'(row_i);
    fc = (c >= WBW - 1) ? c - (WBW - 1) : 0;
    lc = (c > WPR - 1) ? WPR - 1 : c;
    fr = (r >= WBH - 1) ? r - (WBH - 1) : 0;
    lr = (r > WPC - 1) ? WPC - 1 : r;
    fc_o    = COL_W'(fc);
    lc_o    = COL_W'(lc);
    fr_o    = ROW_W'(fr);
    lr_o    = ROW_W'(lr);
    first_o = IDX_W'(fr * WPR + fc);
  end
endmodule

// File: rtl/swsvm_dot.sv
module swsvm_dot #(
  parameter int VEC_LEN = 4,
  parameter int FEAT_W  = 8,
  parameter int WGT_W   = 8,
  parameter int SCORE_W = 22
) (
  input  logic [VEC_LEN*FEAT_W-1:0] vec_i,
  input  logic [VEC_LEN*WGT_W-1:0]  wgt_i,
  output logic signed [SCORE_W-1:0] dot_o
);
  logic signed [SCORE_W-1:0] prod [VEC_LEN];

  for (genvar k = 0; k < VEC_LEN; k++) begin : g_mul
    logic signed [FEAT_W-1:0] x;
    logic signed [WGT_W-1:0]  w;
    assign x = vec_i[k*FEAT_W +: FEAT_W];
    assign w = wgt_i[k*WGT_W +: WGT_W];
    assign prod[k] = SCORE_W'(x) * SCORE_W'(w);
  end

  always_comb begin
    dot_o = '0;
    for (int k = 0; k < VEC_LEN; k++) dot_o = dot_o + prod[k];
  end
endmodule

// File: rtl/swin_svm_acc.sv
module swin_svm_acc #(
  parameter int FRAME_W    = 96,
  parameter int FRAME_H    = 64,
  parameter int WIN_W      = 32,
  parameter int WIN_H      = 32,
  parameter int BLK_W      = 16,
  parameter int BLK_H      = 16,
  parameter int VEC_LEN    = 4,
  parameter int FEAT_W     = 8,
  parameter int WGT_W      = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int FBW       = FRAME_W / BLK_W,
  localparam int FBH       = FRAME_H / BLK_H,
  localparam int WBW       = WIN_W / BLK_W,
  localparam int WBH       = WIN_H / BLK_H,
  localparam int WPR       = FBW - WBW + 1,
  localparam int WPC       = FBH - WBH + 1,
  localparam int NUM_WIN   = WPR * WPC,
  localparam int WGT_DEPTH = WBW * WBH * VEC_LEN,
  localparam int SCORE_W   = FEAT_W + WGT_W + $clog2(WGT_DEPTH + 1) + 2,
  localparam int COL_W     = $clog2(FBW + 1),
  localparam int ROW_W     = $clog2(FBH + 1),
  localparam int IDX_W     = $clog2(NUM_WIN + 1),
  localparam int WA_W      = $clog2(WGT_DEPTH + 1),
  localparam int VEC_W     = VEC_LEN * FEAT_W,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      blk_valid_i,
  output logic                      blk_ready_o,
  input  logic [COL_W-1:0]          blk_col_i,
  input  logic [ROW_W-1:0]          blk_row_i,
  input  logic [VEC_W-1:0]          blk_vec_i,
  input  logic                      wgt_we_i,
  input  logic [WA_W-1:0]           wgt_addr_i,
  input  logic signed [WGT_W-1:0]   wgt_data_i,
  input  logic signed [SCORE_W-1:0] bias_i,
  output logic                      win_valid_o,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic                      win_class_o,
  output logic signed [SCORE_W-1:0] win_score_o
);
  import swsvm_pkg::*;

  localparam int ENT_W = ROW_W + COL_W + VEC_W;

  // input queue
  logic             fifo_full, fifo_empty, fifo_pop, fifo_push;
  logic [ENT_W-1:0] fifo_q;
  logic [CNT_W-1:0] fifo_cnt;

  assign fifo_push   = blk_valid_i && !fifo_full;
  assign blk_ready_o = !fifo_full;

  swsvm_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (fifo_push),
    .data_i ({blk_row_i, blk_col_i, blk_vec_i}),
    .pop_i  (fifo_pop),
    .data_o (fifo_q),
    .full_o (fifo_full),
    .empty_o(fifo_empty),
    .cnt_o  (fifo_cnt)
  );

  logic [ROW_W-1:0] q_row;
  logic [COL_W-1:0] q_col;
  logic [VEC_W-1:0] q_vec;
  assign {q_row, q_col, q_vec} = fifo_q;

  logic [COL_W-1:0] g_fc, g_lc;
  logic [ROW_W-1:0] g_fr, g_lr;
  logic [IDX_W-1:0] g_first;

  swsvm_idx_gen #(
    .FBW(FBW), .FBH(FBH), .WBW(WBW), .WBH(WBH),
    .COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)
  ) u_idx (
    .col_i(q_col), .row_i(q_row),
    .fc_o(g_fc), .lc_o(g_lc), .fr_o(g_fr), .lr_o(g_lr), .first_o(g_first)
  );

  // walker state
  state_t           st;
  logic [COL_W-1:0] b_col, fc, lc, cur_c;
  logic [ROW_W-1:0] b_row, lr, cur_r;
  logic [VEC_W-1:0] b_vec;
  logic [IDX_W-1:0] cur_idx;

  assign fifo_pop = (st == ST_IDLE) && !fifo_empty;

  // weight memory
  logic signed [WGT_W-1:0] wgt_mem [WGT_DEPTH];

  always_ff @(posedge clk_i) begin
    if (wgt_we_i && (int'(wgt_addr_i) < WGT_DEPTH)) wgt_mem[wgt_addr_i] <= wgt_data_i;
  end

  logic [COL_W-1:0] pc;
  logic [ROW_W-1:0] pr;
  assign pc = b_col - cur_c;
  assign pr = b_row - cur_r;

  logic [VEC_LEN*WGT_W-1:0] wgt_slice;
  always_comb begin
    int base;
    base = (int'(pr) * WBW + int'(pc)) * VEC_LEN;
    for (int k = 0; k < VEC_LEN; k++) wgt_slice[k*WGT_W +: WGT_W] = wgt_mem[base + k];
  end

  logic signed [SCORE_W-1:0] dot;
  swsvm_dot #(.VEC_LEN(VEC_LEN), .FEAT_W(FEAT_W), .WGT_W(WGT_W), .SCORE_W(SCORE_W)) u_dot (
    .vec_i(b_vec), .wgt_i(wgt_slice), .dot_o(dot)
  );

  // partial-score read-modify-write
  logic signed [SCORE_W-1:0] score_mem [NUM_WIN];
  logic signed [SCORE_W-1:0] old_score, new_score, fin_score;
  logic                      win_first, win_last, run;

  assign run       = (st == ST_RUN);
  assign win_first = (pc == '0) && (pr == '0);
  assign win_last  = (int'(pc) == WBW - 1) && (int'(pr) == WBH - 1);
  assign old_score = win_first ? '0 : score_mem[cur_idx];
  assign new_score = old_score + dot;
  assign fin_score = new_score + bias_i;

  always_ff @(posedge clk_i) begin
    if (run) score_mem[cur_idx] <= new_score;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      b_col   <= '0;
      b_row   <= '0;
      b_vec   <= '0;
      fc      <= '0;
      lc      <= '0;
      lr      <= '0;
      cur_c   <= '0;
      cur_r   <= '0;
      cur_idx <= '0;
    end else if (st == ST_IDLE) begin
      if (!fifo_empty) begin
        b_col   <= q_col;
        b_row   <= q_row;
        b_vec   <= q_vec;
        fc      <= g_fc;
        lc      <= g_lc;
        lr      <= g_lr;
        cur_c   <= g_fc;
        cur_r   <= g_fr;
        cur_idx <= g_first;
        st      <= ST_RUN;
      end
    end else begin
      if (cur_c != lc) begin
        cur_c   <= cur_c + 1'b1;
        cur_idx <= cur_idx + 1'b1;
      end else if (cur_r != lr) begin
        // jump to first window of next window row
        cur_c   <= fc;
        cur_r   <= cur_r + 1'b1;
        cur_idx <= cur_idx + IDX_W'(WPR) - IDX_W'(lc - fc);
      end else begin
        st <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_valid_o <= 1'b0;
      win_idx_o   <= '0;
      win_class_o <= 1'b0;
      win_score_o <= '0;
    end else begin
      win_valid_o <= run && win_last;
      if (run && win_last) begin
        win_idx_o   <= cur_idx;
        win_score_o <= fin_score;
        win_class_o <= !fin_score[SCORE_W-1];
      end
    end
  end
endmodule

// File: rtl/swin_svm_acc_chk.sv
module swin_svm_acc_chk #(
  parameter int NUM_WIN = 15,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             win_valid_o,
  input logic [IDX_W-1:0] win_idx_o,
  input logic             blk_valid_i,
  input logic             blk_ready_o,
  input logic [CNT_W-1:0] fifo_cnt
);
  logic             seen;
  logic [IDX_W-1:0] last_idx, next_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen     <= 1'b0;
      last_idx <= '0;
    end else if (win_valid_o) begin
      seen     <= 1'b1;
      last_idx <= win_idx_o;
    end
  end

  assign next_idx = (int'(last_idx) == NUM_WIN - 1) ? '0 : last_idx + 1'b1;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |=> !win_valid_o); // R7
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_o |-> (int'(win_idx_o) < NUM_WIN)); // R2
  AST_IDX_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && seen) |-> (win_idx_o == next_idx)); // R2
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blk_valid_i && !blk_ready_o) |=> (fifo_cnt <= $past(fifo_cnt))); // R6
endmodule

bind swin_svm_acc swin_svm_acc_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .win_valid_o(win_valid_o), .win_idx_o(win_idx_o),
  .blk_valid_i(blk_valid_i), .blk_ready_o(blk_ready_o), .fifo_cnt(fifo_cnt)
);

// File: tb/swin_svm_acc_test.sv
module swin_svm_acc_test;
  localparam int CLK_PERIOD = 10;
  localparam int FBW = 6, FBH = 4, WBW = 2, WBH = 2, VEC_LEN = 4;
  localparam int WPR = FBW - WBW + 1, WPC = FBH - WBH + 1, NUM_WIN = WPR * WPC;
  localparam int WGT_DEPTH = WBW * WBH * VEC_LEN;
  localparam int FEAT_W = 8, WGT_W = 8;
  localparam int SCORE_W = FEAT_W + WGT_W + $clog2(WGT_DEPTH + 1) + 2;
  localparam int COL_W = $clog2(FBW + 1), ROW_W = $clog2(FBH + 1);
  localparam int IDX_W = $clog2(NUM_WIN + 1), WA_W = $clog2(WGT_DEPTH + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic blk_valid_i = 1'b0, blk_ready_o;
  logic [COL_W-1:0] blk_col_i = '0;
  logic [ROW_W-1:0] blk_row_i = '0;
  logic [VEC_LEN*FEAT_W-1:0] blk_vec_i = '0;
  logic wgt_we_i = 1'b0;
  logic [WA_W-1:0] wgt_addr_i = '0;
  logic signed [WGT_W-1:0] wgt_data_i = '0;
  logic signed [SCORE_W-1:0] bias_i = '0;
  logic win_valid_o, win_class_o;
  logic [IDX_W-1:0] win_idx_o;
  logic signed [SCORE_W-1:0] win_score_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  swin_svm_acc uut (.*);

  int n_chk = 0, n_err = 0;
  int out_cnt = 0, cur_frame = 0, wset = 0;
  bit saw_full = 0, prev_valid = 0;

  function automatic int feat(int f, int c, int r, int k);
    if (f >= 2) return 0;
    return ((c * 7 + r * 13 + k * 5 + f * 11) % 41) - 20;
  endfunction

  function automatic int wgt(int s, int a);
    if (s == 0) return ((a * 9 + 3) % 31) - 15;
    return ((a * 5 + 7) % 23) - 11;
  endfunction

  function automatic int expect_score(int f, int s, int b, int idx);
    int wc, wr, acc;
    wc = idx % WPR;
    wr = idx / WPR;
    acc = b;
    for (int pr = 0; pr < WBH; pr++)
      for (int pc = 0; pc < WBW; pc++)
        for (int k = 0; k < VEC_LEN; k++)
          acc += wgt(s, (pr * WBW + pc) * VEC_LEN + k) * feat(f, wc + pc, wr + pr, k);
    return acc;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_weights(int s);
    for (int a = 0; a < WGT_DEPTH; a++) begin
      @(negedge clk_i);
      wgt_we_i   = 1'b1;
      wgt_addr_i = WA_W'(a);
      wgt_data_i = WGT_W'(wgt(s, a));
    end
    @(negedge clk_i);
    wgt_we_i = 1'b0;
    wset = s;
  endtask

  task automatic send_frame(int f, int gap);
    for (int r = 0; r < FBH; r++)
      for (int c = 0; c < FBW; c++) begin
        @(negedge clk_i);
        blk_valid_i = 1'b1;
        blk_col_i   = COL_W'(c);
        blk_row_i   = ROW_W'(r);
        for (int k = 0; k < VEC_LEN; k++) blk_vec_i[k*FEAT_W +: FEAT_W] = FEAT_W'(feat(f, c, r, k));
        while (!blk_ready_o) begin
          saw_full = 1;
          @(negedge clk_i);
        end
        @(negedge clk_i);
        blk_valid_i = 1'b0;
        repeat (gap) @(negedge clk_i);
      end
  endtask

  // output monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (win_valid_o) begin
        int exp_idx, exp_s;
        exp_idx = out_cnt % NUM_WIN;
        exp_s   = expect_score(cur_frame, wset, int'(bias_i), exp_idx);
        check("R2 index", int'(win_idx_o), exp_idx);
        check("R3/R5/R8 score", int'(win_score_o), exp_s);
        check("R4 class", int'(win_class_o), (exp_s >= 0) ? 1 : 0);
        if (prev_valid) check("R7 pulse", 1, 0);
        out_cnt++;
      end
      prev_valid = win_valid_o;
    end
  end

  task automatic run_frame(int f, int gap, int b);
    int target;
    cur_frame = f;
    bias_i = SCORE_W'(b);
    target = out_cnt + NUM_WIN;
    send_frame(f, gap);
    repeat (200) @(negedge clk_i);
    check("R2 windows per frame", out_cnt, target);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid after reset", int'(win_valid_o), 0);
    check("R1 ready after reset", int'(blk_ready_o), 1);
    rst_ni = 1'b1;
    load_weights(0);
    run_frame(0, 8, 5);          // spaced input, weight set 0
    load_weights(1);             // R8 reload
    run_frame(1, 0, -100);       // back-to-back input
    check("R6 back-pressure seen", int'(saw_full), 1);
    run_frame(2, 0, 0);          // zero score -> positive (R4)
    run_frame(3, 2, -1);         // -1 -> negative (R4), R5 cleared
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule